// File: doc/BRIEF.md
# Shared-Memory Page Translator

This block sits between two requesters and a block of on-board RAM. One requester is the DMA port of a network controller and the other is a host bus port. Both present 24-bit byte addresses. The block ignores the four most significant address bits. It uses the next ten bits to select one of 1024 page-map slots, and it passes the low ten bits through unchanged as the offset within a 1 KB page. The selected slot supplies a 12-bit frame number, a memory-location attribute and a byte-order attribute. The frame number and the offset together form the physical address that is driven to the memory side.

The host loads the map, and reads it back, as 16-bit words. Both requesters translate through the same map. Two slots may therefore point at the same frame. The top slot is the usual case: it covers the boot-pointer location just under the top of the 24-bit space, and it is normally pointed at frame 0.

An on-board frame number beyond the fitted RAM (256 frames) does not reach memory. The block raises an error pulse instead. When a slot selects controller-native byte order, the block exchanges the two bytes of every 16-bit word in both directions, and it moves byte accesses to the opposite lane. When both ports request in the same cycle, the host is served first.

Top module: `shxl_page_xlat`

## Requirements
- R1: Address bits 23:20 have no effect, bits 19:10 select the map slot, and bits 9:0 appear unchanged on `ram_addr[9:0]` for byte accesses. For word accesses, `ram_addr[0]` is 0.
- R2: `ram_addr[21:10]` equals bits 11:0 of the selected map entry.
- R3: `ram_offboard` equals bit 13 of the selected map entry.
- R4: When bit 13 is 0 and the frame is 256 or higher, `oor_err` pulses and `ram_en` stays low. Frame 255 is accepted.
- R5: When bit 15 is 0, a word write drives `ram_wdata` with the requester's bytes exchanged, and a word read returns the RAM word with its bytes exchanged. When bit 15 is 1, words pass through unchanged. Word accesses drive `ram_be` to 2'b11.
- R6: A byte access uses lane L, where L = address bit 0 XOR (NOT bit 15). Lane 0 is bits 7:0 with `ram_be` = 2'b01, and lane 1 is bits 15:8 with `ram_be` = 2'b10. Write data comes from bits 7:0 of the requester's data and is copied onto both lanes. Read data returns in bits 7:0, with bits 15:8 set to 0.
- R7: A map write takes effect for translations that start in the next cycle. A translation that starts in the same cycle as the write uses the old entry.
- R8: A map read (`map_rd`) presents the slot's 16-bit entry on `map_rdata` in the next cycle.
- R9: When both ports request in the same cycle, only `h_gnt` is high. `c_gnt` is high whenever the controller requests and the host does not.
- R10: Two slots that hold the same on-board frame produce the same physical address for the same offset. This includes slot 1023, which covers address 0xFFFFF4.
- R11: The RAM command (`ram_en` or `oor_err`) appears one cycle after a grant. Read data and the owner's `*_rvalid` appear in that same cycle, and writes raise no `*_rvalid`.
- R12: During reset and after its release, the grants, `ram_en`, `oor_err` and both `*_rvalid` are low until a request is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_wr | input | 1 | Write the map slot `map_idx` |
| map_rd | input | 1 | Read the map slot `map_idx` |
| map_idx | input | 10 | Map slot index |
| map_wdata | input | 16 | Entry to write |
| map_rdata | output | 16 | Entry read back, one cycle later |
| c_req | input | 1 | Controller access request |
| c_addr | input | 24 | Controller byte address |
| c_we | input | 1 | Controller write |
| c_byte | input | 1 | Controller byte access |
| c_wdata | input | 16 | Controller write data |
| c_gnt | output | 1 | Controller request accepted this cycle |
| c_rvalid | output | 1 | Controller read data valid |
| c_rdata | output | 16 | Controller read data |
| h_req | input | 1 | Host access request |
| h_addr | input | 24 | Host byte address |
| h_we | input | 1 | Host write |
| h_byte | input | 1 | Host byte access |
| h_wdata | input | 16 | Host write data |
| h_gnt | output | 1 | Host request accepted this cycle |
| h_rvalid | output | 1 | Host read data valid |
| h_rdata | output | 16 | Host read data |
| ram_en | output | 1 | Memory access strobe |
| ram_we | output | 1 | Memory write |
| ram_addr | output | 22 | Physical byte address (frame, offset) |
| ram_be | output | 2 | Byte-lane enables |
| ram_wdata | output | 16 | Memory write data |
| ram_rdata | input | 16 | Memory read data, valid in the same cycle as `ram_en` |
| ram_offboard | output | 1 | Access targets the expansion bus |
| oor_err | output | 1 | On-board frame out of range; access dropped |

## Verification
Two functions can fall into the same cycle. The first is a host map write colliding with a translation that reads the slot being written. The bench provokes this by driving `map_wr` and a controller request to that slot on the same edge. It expects the physical address to carry the old frame, and the following request to carry the new one. The second collision is between the two ports. The bench raises both requests together and judges the result from the grants and from the order of `ram_addr` values: the host's address comes first, and the controller's follows one cycle later.

// File: rtl/shxl_pkg.sv
package shxl_pkg;
  localparam int ADDR_W  = 24;
  localparam int IDX_W   = 10;
  localparam int OFF_W   = 10;
  localparam int FRAME_W = 12;
  localparam int DATA_W  = 16;
  localparam int PADDR_W = FRAME_W + OFF_W;

  // map entry layout: bit 15 host byte order, bit 13 expansion bus, 11:0 frame
  typedef struct packed {
    logic               host_order;
    logic               rsvd_a;
    logic               offboard;
    logic               rsvd_b;
    logic [FRAME_W-1:0] frame;
  } map_entry_t;

  typedef struct packed {
    logic [PADDR_W-1:0] paddr;
    logic               swap;
    logic               lane;
    logic [1:0]         be;
    logic               offboard;
    logic               oor;
  } xlat_res_t;
endpackage

// File: rtl/shxl_map_store.sv
module shxl_map_store
  import shxl_pkg::*;
#(
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [IW-1:0] host_idx,
  input  logic [15:0]   wr_data,
  output logic [15:0]   rd_data,
  input  logic [IW-1:0] xa_idx,
  output map_entry_t    xa_ent,
  input  logic [IW-1:0] xb_idx,
  output map_entry_t    xb_ent
);
  localparam int DEPTH = 1 << IW;

  logic [15:0] slots [DEPTH];
  logic [15:0] rd_data_d;

  // storage carries no reset; software loads every slot it uses
  always_ff @(posedge clk) begin
    if (wr_en) slots[host_idx] <= wr_data;
  end

  always_comb begin
    rd_data_d = rd_en ? slots[host_idx] : rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_data_d;
  end

  assign xa_ent = map_entry_t'(slots[xa_idx]);
  assign xb_ent = map_entry_t'(slots[xb_idx]);
endmodule

// File: rtl/shxl_xlat.sv
module shxl_xlat
  import shxl_pkg::*;
#(
  parameter int NUM_PAGES = 256
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              byte_acc,
  input  map_entry_t        ent,
  output xlat_res_t         res
);
  logic [OFF_W-1:0] off;
  logic             unused_bits;

  assign unused_bits = ^{addr[ADDR_W-1:OFF_W+IDX_W], ent.rsvd_a, ent.rsvd_b};

  always_comb begin
    off          = addr[OFF_W-1:0];
    if (!byte_acc) off[0] = 1'b0;
    res.paddr    = {ent.frame, off};
    res.swap     = ~ent.host_order;
    res.lane     = addr[0] ^ res.swap;
    res.be       = byte_acc ? (res.lane ? 2'b10 : 2'b01) : 2'b11;
    res.offboard = ent.offboard;
    res.oor      = ~ent.offboard && (32'(ent.frame) >= NUM_PAGES);
  end
endmodule

// File: rtl/shxl_lane_mux.sv
module shxl_lane_mux
  import shxl_pkg::*;
(
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              wr_byte,
  input  logic              wr_swap,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              rd_byte,
  input  logic              rd_swap,
  input  logic              rd_lane,
  output logic [DATA_W-1:0] req_rdata
);
  localparam int HB = DATA_W / 2;

  always_comb begin
    if (wr_byte)      mem_wdata = {req_wdata[HB-1:0], req_wdata[HB-1:0]};
    else if (wr_swap) mem_wdata = {req_wdata[HB-1:0], req_wdata[DATA_W-1:HB]};
    else              mem_wdata = req_wdata;

    if (rd_byte)      req_rdata = {{HB{1'b0}}, rd_lane ? mem_rdata[DATA_W-1:HB] : mem_rdata[HB-1:0]};
    else if (rd_swap) req_rdata = {mem_rdata[HB-1:0], mem_rdata[DATA_W-1:HB]};
    else              req_rdata = mem_rdata;
  end
endmodule

// File: rtl/shxl_page_xlat.sv
module shxl_page_xlat
  import shxl_pkg::*;
#(
  parameter int NUM_PAGES = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               map_wr,
  input  logic               map_rd,
  input  logic [IDX_W-1:0]   map_idx,
  input  logic [15:0]        map_wdata,
  output logic [15:0]        map_rdata,
  input  logic               c_req,
  input  logic [ADDR_W-1:0]  c_addr,
  input  logic               c_we,
  input  logic               c_byte,
  input  logic [DATA_W-1:0]  c_wdata,
  output logic               c_gnt,
  output logic               c_rvalid,
  output logic [DATA_W-1:0]  c_rdata,
  input  logic               h_req,
  input  logic [ADDR_W-1:0]  h_addr,
  input  logic               h_we,
  input  logic               h_byte,
  input  logic [DATA_W-1:0]  h_wdata,
  output logic               h_gnt,
  output logic               h_rvalid,
  output logic [DATA_W-1:0]  h_rdata,
  output logic               ram_en,
  output logic               ram_we,
  output logic [PADDR_W-1:0] ram_addr,
  output logic [1:0]         ram_be,
  output logic [DATA_W-1:0]  ram_wdata,
  input  logic [DATA_W-1:0]  ram_rdata,
  output logic               ram_offboard,
  output logic               oor_err
);
  localparam int NPORT = 2;   // port 0 controller, port 1 host

  // reset release synchronizer
  logic rs_q1, rs_q2, run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign run = rs_q2;

  // map
  map_entry_t ent [NPORT];
  shxl_map_store #(.IW(IDX_W)) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (map_wr & run),
    .rd_en   (map_rd & run),
    .host_idx(map_idx),
    .wr_data (map_wdata),
    .rd_data (map_rdata),
    .xa_idx  (c_addr[OFF_W +: IDX_W]),
    .xa_ent  (ent[0]),
    .xb_idx  (h_addr[OFF_W +: IDX_W]),
    .xb_ent  (ent[1])
  );

  // per-port translation
  logic [ADDR_W-1:0] p_addr [NPORT];
  logic              p_byte [NPORT];
  xlat_res_t         p_res  [NPORT];
  assign p_addr[0] = c_addr;
  assign p_addr[1] = h_addr;
  assign p_byte[0] = c_byte;
  assign p_byte[1] = h_byte;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    shxl_xlat #(.NUM_PAGES(NUM_PAGES)) u_xlat (
      .addr    (p_addr[g]),
      .byte_acc(p_byte[g]),
      .ent     (ent[g]),
      .res     (p_res[g])
    );
  end

  // fixed-priority arbitration, host first
  assign h_gnt = run & h_req;
  assign c_gnt = run & c_req & ~h_req;

  // selected request, next state
  xlat_res_t         sel_res;
  logic              sel_we, sel_byte, issue_en;
  logic [DATA_W-1:0] sel_wdata, mux_wdata, mux_rdata;

  always_comb begin
    issue_en  = h_gnt | c_gnt;
    sel_res   = h_gnt ? p_res[1] : p_res[0];
    sel_we    = h_gnt ? h_we     : c_we;
    sel_byte  = h_gnt ? h_byte   : c_byte;
    sel_wdata = h_gnt ? h_wdata  : c_wdata;
  end

  logic ram_en_d, oor_d, rd_pend_d;
  always_comb begin
    ram_en_d  = issue_en & ~sel_res.oor;
    oor_d     = issue_en &  sel_res.oor;
    rd_pend_d = ram_en_d & ~sel_we;
  end

  // registered command and response context
  logic rd_pend_q, own_host_q, rsp_byte_q, rsp_swap_q, rsp_lane_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_en    <= 1'b0;
      oor_err   <= 1'b0;
      rd_pend_q <= 1'b0;
    end else begin
      ram_en    <= ram_en_d;
      oor_err   <= oor_d;
      rd_pend_q <= rd_pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_we       <= 1'b0;
      ram_addr     <= '0;
      ram_be       <= '0;
      ram_wdata    <= '0;
      ram_offboard <= 1'b0;
      own_host_q   <= 1'b0;
      rsp_byte_q   <= 1'b0;
      rsp_swap_q   <= 1'b0;
      rsp_lane_q   <= 1'b0;
    end else if (issue_en) begin
      ram_we       <= sel_we;
      ram_addr     <= sel_res.paddr;
      ram_be       <= sel_res.be;
      ram_wdata    <= mux_wdata;
      ram_offboard <= sel_res.offboard;
      own_host_q   <= h_gnt;
      rsp_byte_q   <= sel_byte;
      rsp_swap_q   <= sel_res.swap;
      rsp_lane_q   <= sel_res.lane;
    end
  end

  shxl_lane_mux u_lanes (
    .req_wdata(sel_wdata),
    .wr_byte  (sel_byte),
    .wr_swap  (sel_res.swap),
    .mem_wdata(mux_wdata),
    .mem_rdata(ram_rdata),
    .rd_byte  (rsp_byte_q),
    .rd_swap  (rsp_swap_q),
    .rd_lane  (rsp_lane_q),
    .req_rdata(mux_rdata)
  );

  assign h_rvalid = rd_pend_q &  own_host_q;
  assign c_rvalid = rd_pend_q & ~own_host_q;
  assign h_rdata  = h_rvalid ? mux_rdata : '0;
  assign c_rdata  = c_rvalid ? mux_rdata : '0;
endmodule

// File: rtl/shxl_page_xlat_chk.sv
module shxl_page_xlat_chk #(
  parameter int NUM_PAGES = 256,
  parameter int PW = 22,
  parameter int OW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          c_req,
  input logic          h_req,
  input logic          c_gnt,
  input logic          h_gnt,
  input logic          c_rvalid,
  input logic          h_rvalid,
  input logic          ram_en,
  input logic          ram_we,
  input logic [PW-1:0] ram_addr,
  input logic          ram_offboard,
  input logic          oor_err
);
  p_host_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req && c_req) |-> !c_gnt);

  p_one_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({h_gnt, c_gnt}));

  p_oor_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    oor_err |-> !ram_en);

  p_frame_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && !ram_offboard) |-> (32'(ram_addr[PW-1:OW]) < NUM_PAGES));

  p_issue_after_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (h_gnt || c_gnt) |=> (ram_en || oor_err));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_gnt || c_gnt) |=> (!ram_en && !oor_err && !h_rvalid && !c_rvalid));

  p_no_rvalid_on_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && ram_we) |-> (!h_rvalid && !c_rvalid));
endmodule

bind shxl_page_xlat shxl_page_xlat_chk #(
  .NUM_PAGES(NUM_PAGES),
  .PW(shxl_pkg::PADDR_W),
  .OW(shxl_pkg::OFF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .c_req(c_req), .h_req(h_req),
  .c_gnt(c_gnt), .h_gnt(h_gnt), .c_rvalid(c_rvalid), .h_rvalid(h_rvalid),
  .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
  .ram_offboard(ram_offboard), .oor_err(oor_err)
);

// File: tb/shxl_page_xlat_tb_top.sv
`timescale 1ns/1ps
module shxl_page_xlat_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic        rst_n;
  logic        map_wr, map_rd;
  logic [9:0]  map_idx;
  logic [15:0] map_wdata, map_rdata;
  logic        c_req, c_we, c_byte, c_gnt, c_rvalid;
  logic [23:0] c_addr;
  logic [15:0] c_wdata, c_rdata;
  logic        h_req, h_we, h_byte, h_gnt, h_rvalid;
  logic [23:0] h_addr;
  logic [15:0] h_wdata, h_rdata;
  logic        ram_en, ram_we, ram_offboard, oor_err;
  logic [21:0] ram_addr;
  logic [1:0]  ram_be;
  logic [15:0] ram_wdata, ram_rdata;

  shxl_page_xlat dut_i (.*);

  // memory model: frames distinguished by their low 3 bits
  logic [15:0] mem [4096];
  wire  [11:0] mem_idx = {ram_addr[12:10], ram_addr[9:1]};
  assign ram_rdata = mem[mem_idx];
  always @(posedge clk) begin
    if (ram_en && ram_we && !ram_offboard) begin
      if (ram_be[0]) mem[mem_idx][7:0]  <= ram_wdata[7:0];
      if (ram_be[1]) mem[mem_idx][15:8] <= ram_wdata[15:8];
    end
  end

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8ns * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic mapw(input logic [9:0] idx, input logic [15:0] v);
    @(negedge clk);
    map_wr = 1; map_idx = idx; map_wdata = v;
    @(negedge clk);
    map_wr = 0;
  endtask

  logic g_seen;
  // one access; on return, the registered results are visible
  task automatic acc(input bit host, input logic [23:0] a, input bit we,
                     input bit bt, input logic [15:0] wd);
    @(negedge clk);
    if (host) begin h_req = 1; h_addr = a; h_we = we; h_byte = bt; h_wdata = wd; end
    else      begin c_req = 1; c_addr = a; c_we = we; c_byte = bt; c_wdata = wd; end
    #1 g_seen = host ? h_gnt : c_gnt;
    @(posedge clk);
    @(negedge clk);
    h_req = 0; c_req = 0;
  endtask

  // host?, addr, byte, wdata, exp addr, exp be, exp wdata, exp offboard, exp oor
  localparam int NV = 8;
  localparam logic [83:0] VEC [NV] = '{
    {1'b1, 24'h000010, 1'b0, 16'hA1B2, 22'h000010, 2'b11, 16'hA1B2, 1'b0, 1'b0},
    {1'b0, 24'hF00010, 1'b0, 16'hA1B2, 22'h000010, 2'b11, 16'hA1B2, 1'b0, 1'b0},
    {1'b0, 24'h000404, 1'b0, 16'h1234, 22'h001404, 2'b11, 16'h3412, 1'b0, 1'b0},
    {1'b1, 24'h000405, 1'b1, 16'h00CD, 22'h001405, 2'b01, 16'hCDCD, 1'b0, 1'b0},
    {1'b1, 24'h000011, 1'b1, 16'h00EE, 22'h000011, 2'b10, 16'hEEEE, 1'b0, 1'b0},
    {1'b0, 24'h000820, 1'b0, 16'h5555, 22'h048C20, 2'b11, 16'h5555, 1'b1, 1'b0},
    {1'b1, 24'h000C00, 1'b0, 16'h7777, 22'h000000, 2'b00, 16'h0000, 1'b0, 1'b1},
    {1'b0, 24'h0013FE, 1'b0, 16'h0102, 22'h03FFFE, 2'b11, 16'h0201, 1'b0, 1'b0}
  };

  initial begin
    rst_n = 0; map_wr = 0; map_rd = 0; map_idx = '0; map_wdata = '0;
    c_req = 0; c_addr = '0; c_we = 0; c_byte = 0; c_wdata = '0;
    h_req = 0; h_addr = '0; h_we = 0; h_byte = 0; h_wdata = '0;
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R12: quiet while in reset
    chk("R12 ram_en in reset", ram_en, 0);
    chk("R12 oor_err in reset", oor_err, 0);
    chk("R12 rvalid in reset", {h_rvalid, c_rvalid}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R12 ram_en after release", ram_en, 0);
    chk("R12 grants idle", {h_gnt, c_gnt}, 0);

    mapw(10'd0,    16'h8000);  // frame 0, host order
    mapw(10'd1,    16'h0005);  // frame 5, native order (swap)
    mapw(10'd2,    16'hA123);  // frame 0x123 on expansion bus
    mapw(10'd3,    16'h012C);  // frame 300 on-board: out of range
    mapw(10'd4,    16'h00FF);  // frame 255, swap
    mapw(10'd5,    16'h8005);  // frame 5, host order
    mapw(10'd6,    16'h800A);  // frame 10
    mapw(10'd1023, 16'h8000);  // top slot aliases frame 0

    // R8: map readback
    @(negedge clk); map_rd = 1; map_idx = 10'd2;
    @(negedge clk); map_rd = 0;
    chk("R8 map_rdata", map_rdata, 16'hA123);

    // table of write accesses (R1 R2 R3 R4 R5 R6 R11)
    for (int v = 0; v < NV; v++) begin
      logic [83:0] e;
      e = VEC[v];
      acc(e[83], e[82:59], 1'b1, e[58], e[57:42]);
      chk("R9 grant single port", g_seen, 1);
      chk("R4 oor_err", oor_err, e[0]);
      chk("R11 ram_en after grant", ram_en, !e[0]);
      if (!e[0]) begin
        chk("R2 ram_addr", ram_addr, e[41:20]);
        chk("R6 ram_be", ram_be, e[19:18]);
        chk("R5 ram_wdata", ram_wdata, e[17:2]);
        chk("R3 ram_offboard", ram_offboard, e[1]);
        chk("R11 no rvalid on write", {h_rvalid, c_rvalid}, 0);
      end
    end

    // R5: word swap in both directions
    acc(0, 24'h000408, 1, 0, 16'h1234);
    acc(0, 24'h000408, 0, 0, 16'h0000);
    chk("R11 c_rvalid", c_rvalid, 1);
    chk("R11 h_rvalid idle", h_rvalid, 0);
    chk("R5 swapped read", c_rdata, 16'h1234);
    acc(1, 24'h001408, 0, 0, 16'h0000);
    chk("R5 straight read of stored word", h_rdata, 16'h3412);
    // R6: byte read, swap, odd address -> lane 0
    acc(1, 24'h000409, 0, 1, 16'h0000);
    chk("R6 byte read lane", h_rdata, 16'h0012);
    acc(1, 24'h001409, 0, 1, 16'h0000);
    chk("R6 byte read host order", h_rdata, 16'h0034);

    // R10 / R1: boot-pointer slot aliases frame 0, top nibble ignored
    acc(1, 24'hFFFFF4, 1, 0, 16'hBEEF);
    chk("R10 top slot address", ram_addr, 22'h0003F4);
    acc(0, 24'h5003F4, 0, 0, 16'h0000);
    chk("R1 top nibble ignored", ram_addr, 22'h0003F4);
    chk("R10 alias read", c_rdata, 16'hBEEF);

    // R9: simultaneous requests
    @(negedge clk);
    h_req = 1; h_addr = 24'h000020; h_we = 1; h_byte = 0; h_wdata = 16'h1111;
    c_req = 1; c_addr = 24'h000030; c_we = 1; c_byte = 0; c_wdata = 16'h2222;
    #1 chk("R9 both: host grant", {h_gnt, c_gnt}, 2'b10);
    @(posedge clk); @(negedge clk);
    h_req = 0;
    chk("R9 host served first", ram_addr, 22'h000020);
    #1 chk("R9 controller next", c_gnt, 1);
    @(posedge clk); @(negedge clk);
    c_req = 0;
    chk("R9 controller served", ram_addr, 22'h000030);

    // R7: map write and translation of the same slot in one cycle
    @(negedge clk);
    map_wr = 1; map_idx = 10'd6; map_wdata = 16'h8014;
    c_req = 1; c_addr = 24'h001800; c_we = 1; c_byte = 0; c_wdata = 16'h0;
    @(posedge clk); @(negedge clk);
    map_wr = 0; c_req = 0;
    chk("R7 same-cycle uses old entry", ram_addr, 22'h002800);
    acc(0, 24'h001800, 1, 0, 16'h0000);
    chk("R7 next cycle uses new entry", ram_addr, 22'h005000);

    repeat (2) @(negedge clk);
    chk("R11 idle after traffic", {ram_en, oor_err}, 0);
    finish_run();
  end
endmodule